// File: doc/BRIEF.md
# Three-Phase PWM Dead-Time Inserter

This block sits between a PWM timer and the gate drivers of a three-phase bridge. The timer gives one raw phase signal per leg. For each leg the block drives a high-side gate and a low-side gate that are complementary. After every level change of the phase signal, both gates stay off for a programmed number of clock cycles before the new side turns on.

Each leg has its own 8-bit gap counter. A phase pulse can be shorter than the programmed gap. The block then behaves in one of two ways, chosen by a mode bit. In the restart mode, every new edge starts the gap over from zero. In the shrink mode, the counter turns around and counts down. The gap after the second edge is then only as long as the pulse was, so the applied dead time narrows on its own. While the timer enable is low, all gates are off and the counters are cleared. The mode bit can only be changed while the timer is stopped.

Top module: `pwm_deadtime3`

## Requirements
- R1: Each of the three legs drives `gate_top[i]` while its settled phase level is 1 and `gate_bot[i]` while its settled phase level is 0.
- R2: With `dt_width` = W ≥ 1, a phase level change that is sampled at clock edge k turns both gates of that leg off from edge k onward. The new side turns on at edge k+W, provided no further change occurs.
- R3: With `dt_width` = 0 there is no gap. On the edge after a phase change, each gate shows the new level: top equals phase and bottom equals its inverse.
- R4: Restart mode (mode value 0). If a leg's phase changes again before its gap has finished, the gap starts over. The new side turns on W edges after the latest change.
- R5: Shrink mode (mode value 1). Suppose a second change arrives c edges after the first, with c < W. The counter reverses, and the new side turns on c edges after the second change.
- R6: An edge at which `tmr_en` is sampled low forces all six gates low and clears every counter. After `tmr_en` rises, with the phases steady and W ≥ 1, the active side turns on at the W-th edge at which enable is sampled high.
- R7: A write (`mode_wr` = 1) updates the mode from `mode_wdata` when `tmr_en` is low. While `tmr_en` is high, a write that would change the mode is ignored.
- R8: Reset (synchronous, active-high `rst`) clears the mode to 0 (restart) and drives all gates low.
- R9: `gate_top[i]` and `gate_bot[i]` are never high together, whatever the width, mode or stimulus.
- R10: The legs are independent. An edge on one phase has no effect on the gap timing or the gates of the other legs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock; the gap counters advance once per cycle |
| rst | input | 1 | Synchronous active-high reset |
| tmr_en | input | 1 | Timer running; low forces the gates off |
| phase_in | input | 3 | Raw PWM level per leg |
| dt_width | input | 8 | Dead-time width in clock cycles; 0 disables the gap |
| mode_wr | input | 1 | Write strobe for the narrow-pulse mode |
| mode_wdata | input | 1 | Mode value: 0 restart, 1 shrink |
| gate_top | output | 3 | High-side gate per leg |
| gate_bot | output | 3 | Low-side gate per leg |

## Verification
The hardest case to reach is the reversal in shrink mode. A second phase edge has to land while a gap is still counting up. Then its shortened gap has to be told apart from a restarted one. The bench first stops the timer so that the mode can be switched. It lets the legs settle at a gap of six cycles, then sends a two-cycle pulse. The new low side must come on exactly two cycles after the falling edge. The same pulse is repeated after a mode write made while running, to show that the write was refused.

// File: rtl/pwm_deadtime3_pkg.sv
package pwm_deadtime3_pkg;

    localparam int unsigned DT_CW  = 8;
    localparam int unsigned DT_NPH = 3;

    typedef logic [DT_CW-1:0] dt_cnt_t;

    typedef enum logic {
        DIR_UP = 1'b0,
        DIR_DN = 1'b1
    } dt_dir_e;

    typedef enum logic {
        NARROW_RESTART = 1'b0,
        NARROW_SHRINK  = 1'b1
    } narrow_mode_e;

    typedef struct packed {
        dt_cnt_t cnt;   // gap counter
        dt_dir_e dir;   // counting direction
        logic    open;  // gap finished, active side may drive
        logic    lvl;   // settled phase level
    } leg_state_t;

    // Up-count reaches the programmed width on this cycle.
    function automatic logic gap_reached(input dt_cnt_t cnt, input dt_cnt_t width);
        logic [DT_CW:0] nxt;
        nxt = {1'b0, cnt} + {{DT_CW{1'b0}}, 1'b1};
        return nxt >= {1'b0, width};
    endfunction

endpackage

// File: rtl/pwm_deadtime3_modereg.sv
module pwm_deadtime3_modereg
    import pwm_deadtime3_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         tmr_en,
    input  logic         wr,
    input  logic         wdata,
    output narrow_mode_e mode
);

    narrow_mode_e req;
    logic         accept;

    always_comb begin
        req    = narrow_mode_e'(wdata);
        // Running timer: only a write of the value already held gets through.
        accept = wr && (!tmr_en || (req == mode));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode <= NARROW_RESTART;
        end else if (accept) begin
            mode <= req;
        end
    end

endmodule

// File: rtl/pwm_deadtime3_leg.sv
module pwm_deadtime3_leg
    import pwm_deadtime3_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         tmr_en,
    input  logic         din,
    input  dt_cnt_t      width,
    input  narrow_mode_e mode,
    output logic         top,
    output logic         bot
);

    leg_state_t st, nx;
    logic       no_gap;

    assign no_gap = (width == '0);

    always_comb begin
        nx = st;
        if (!tmr_en) begin
            nx.cnt  = '0;
            nx.dir  = DIR_UP;
            nx.open = 1'b0;
            nx.lvl  = din;
        end else if (din != st.lvl) begin
            nx.lvl = din;
            if (no_gap) begin
                nx.open = 1'b1;
                nx.cnt  = '0;
                nx.dir  = DIR_UP;
            end else if (st.open || mode == NARROW_RESTART) begin
                nx.open = 1'b0;
                nx.cnt  = '0;
                nx.dir  = DIR_UP;
            end else begin
                // Shrink mode, edge inside a gap: turn the count around.
                nx.dir = (st.dir == DIR_UP) ? DIR_DN : DIR_UP;
            end
        end else if (!st.open) begin
            if (no_gap) begin
                nx.open = 1'b1;
                nx.cnt  = '0;
                nx.dir  = DIR_UP;
            end else if (st.dir == DIR_UP) begin
                if (gap_reached(st.cnt, width)) begin
                    nx.open = 1'b1;
                    nx.cnt  = '0;
                end else begin
                    nx.cnt = st.cnt + 1'b1;
                end
            end else begin
                if (st.cnt == '0) begin
                    nx.open = 1'b1;
                    nx.dir  = DIR_UP;
                end else begin
                    nx.cnt = st.cnt - 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= '{cnt: '0, dir: DIR_UP, open: 1'b0, lvl: din};
            top <= 1'b0;
            bot <= 1'b0;
        end else begin
            st  <= nx;
            top <= nx.open &  nx.lvl;
            bot <= nx.open & ~nx.lvl;
        end
    end

endmodule

// File: rtl/pwm_deadtime3.sv
module pwm_deadtime3
    import pwm_deadtime3_pkg::*;
#(
    parameter int unsigned NPH = DT_NPH,
    parameter int unsigned CW  = DT_CW
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           tmr_en,
    input  logic [NPH-1:0] phase_in,
    input  logic [CW-1:0]  dt_width,
    input  logic           mode_wr,
    input  logic           mode_wdata,
    output logic [NPH-1:0] gate_top,
    output logic [NPH-1:0] gate_bot
);

    narrow_mode_e mode_q;
    dt_cnt_t      width_c;

    assign width_c = dt_cnt_t'(dt_width);

    pwm_deadtime3_modereg u_mode (
        .clk   (clk),
        .rst   (rst),
        .tmr_en(tmr_en),
        .wr    (mode_wr),
        .wdata (mode_wdata),
        .mode  (mode_q)
    );

    for (genvar i = 0; i < NPH; i++) begin : g_leg
        pwm_deadtime3_leg u_leg (
            .clk   (clk),
            .rst   (rst),
            .tmr_en(tmr_en),
            .din   (phase_in[i]),
            .width (width_c),
            .mode  (mode_q),
            .top   (gate_top[i]),
            .bot   (gate_bot[i])
        );
    end

endmodule

// File: rtl/pwm_deadtime3_chk.sv
module pwm_deadtime3_chk #(
    parameter int unsigned NPH = 3,
    parameter int unsigned CW  = 8
) (
    input logic           clk,
    input logic           rst,
    input logic           tmr_en,
    input logic [NPH-1:0] phase_in,
    input logic [CW-1:0]  dt_width,
    input logic           mode_q,
    input logic [NPH-1:0] gate_top,
    input logic [NPH-1:0] gate_bot
);

    assert_gates_off_when_stopped_R6: assert property (@(posedge clk) disable iff (rst)
        !tmr_en |=> (gate_top == '0) && (gate_bot == '0));

    assert_mode_locked_R7: assert property (@(posedge clk) disable iff (rst)
        tmr_en |=> $stable(mode_q));

    for (genvar i = 0; i < NPH; i++) begin : g_leg_chk
        assert_no_shoot_through_R9: assert property (@(posedge clk) disable iff (rst)
            !(gate_top[i] && gate_bot[i]));

        assert_edge_blanks_R2: assert property (@(posedge clk) disable iff (rst)
            (tmr_en && (dt_width != '0) && (phase_in[i] != $past(phase_in[i])))
            |=> (!gate_top[i] && !gate_bot[i]));
    end

endmodule

bind pwm_deadtime3 pwm_deadtime3_chk #(.NPH(NPH), .CW(CW)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .tmr_en  (tmr_en),
    .phase_in(phase_in),
    .dt_width(dt_width),
    .mode_q  (mode_q),
    .gate_top(gate_top),
    .gate_bot(gate_bot)
);

// File: tb/pwm_deadtime3_bench.sv
module pwm_deadtime3_bench;

    logic       clk = 1'b0;
    logic       rst;
    logic       tmr_en;
    logic [2:0] phase_in;
    logic [7:0] dt_width;
    logic       mode_wr;
    logic       mode_wdata;
    logic [2:0] gate_top;
    logic [2:0] gate_bot;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    pwm_deadtime3 u_pwm_deadtime3 (
        .clk       (clk),
        .rst       (rst),
        .tmr_en    (tmr_en),
        .phase_in  (phase_in),
        .dt_width  (dt_width),
        .mode_wr   (mode_wr),
        .mode_wdata(mode_wdata),
        .gate_top  (gate_top),
        .gate_bot  (gate_bot)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic steps(input int n);
        for (int k = 0; k < n; k++) step();
    endtask

    task automatic expect_gates(input string req, input logic [2:0] et, input logic [2:0] eb);
        n_checks++;
        if (gate_top !== et || gate_bot !== eb) begin
            n_fails++;
            $display("FAIL %s: top=%b bot=%b expected top=%b bot=%b at %0t",
                     req, gate_top, gate_bot, et, eb, $time);
        end
    endtask

    task automatic write_mode(input logic v);
        mode_wr = 1'b1; mode_wdata = v;
        step();
        mode_wr = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1; tmr_en = 1'b0; phase_in = '0; dt_width = '0;
        mode_wr = 1'b0; mode_wdata = 1'b0;
        steps(3);
        expect_gates("R8 reset", 3'b000, 3'b000);
        rst = 1'b0;
        step();
        expect_gates("R8 after reset", 3'b000, 3'b000);
    endtask

    task automatic t_startup();
        dt_width = 8'd3; tmr_en = 1'b1;
        step(); expect_gates("R6 startup e1", 3'b000, 3'b000);
        step(); expect_gates("R6 startup e2", 3'b000, 3'b000);
        step(); expect_gates("R6 startup e3", 3'b000, 3'b111);
    endtask

    task automatic t_basic_gap();
        phase_in = 3'b001;
        step(); expect_gates("R2 rise gap k", 3'b000, 3'b110);
        steps(2); expect_gates("R2 rise gap k+2", 3'b000, 3'b110);
        step(); expect_gates("R1 rise top on k+3", 3'b001, 3'b110);
        phase_in = 3'b000;
        steps(3); expect_gates("R2 fall gap k+2", 3'b000, 3'b110);
        step(); expect_gates("R1 fall bot on k+3", 3'b000, 3'b111);
    endtask

    // Mode still at its reset value: narrow pulse restarts the gap.
    task automatic t_narrow_restart();
        dt_width = 8'd6;
        phase_in = 3'b001;
        steps(2); expect_gates("R4 pulse blanked", 3'b000, 3'b110);
        phase_in = 3'b000;
        step();
        steps(5); expect_gates("R4 R8 restarted gap still off", 3'b000, 3'b110);
        step(); expect_gates("R4 R8 bot on W after last edge", 3'b000, 3'b111);
    endtask

    task automatic t_stop_and_switch();
        tmr_en = 1'b0;
        step(); expect_gates("R6 stopped", 3'b000, 3'b000);
        phase_in = 3'b101;
        step(); expect_gates("R6 stopped ignores phase", 3'b000, 3'b000);
        phase_in = 3'b000;
        write_mode(1'b1);
        tmr_en = 1'b1;
        steps(5); expect_gates("R6 restart e5", 3'b000, 3'b000);
        step(); expect_gates("R6 restart e6", 3'b000, 3'b111);
    endtask

    task automatic shrink_pulse(input string tag);
        phase_in = 3'b001;
        steps(2); expect_gates(tag, 3'b000, 3'b110);
        phase_in = 3'b000;
        steps(2); expect_gates(tag, 3'b000, 3'b110);
        step(); expect_gates(tag, 3'b000, 3'b111);
    endtask

    task automatic t_narrow_shrink();
        shrink_pulse("R5 shrink gap equals pulse");
    endtask

    task automatic t_mode_lock();
        write_mode(1'b0);
        shrink_pulse("R7 running write refused");
        write_mode(1'b1);
        shrink_pulse("R7 same value write");
    endtask

    task automatic t_zero_width();
        dt_width = 8'd0; phase_in = 3'b101;
        step(); expect_gates("R3 zero width follow", 3'b101, 3'b010);
        phase_in = 3'b010;
        step(); expect_gates("R3 zero width toggle", 3'b010, 3'b101);
    endtask

    task automatic t_independent();
        dt_width = 8'd4; phase_in = 3'b000;
        steps(6); expect_gates("R10 settle", 3'b000, 3'b111);
        phase_in = 3'b001;
        step();
        step(); expect_gates("R10 leg1 untouched", 3'b000, 3'b110);
        phase_in = 3'b011;
        steps(2); expect_gates("R10 both gapped", 3'b000, 3'b100);
        step(); expect_gates("R10 leg0 on", 3'b001, 3'b100);
        step(); expect_gates("R10 leg1 still gapped", 3'b001, 3'b100);
        step(); expect_gates("R10 leg1 on", 3'b011, 3'b100);
    endtask

    task automatic t_overlap_sweep();
        logic [15:0] lfsr = 16'hACE1;
        int bad = 0;
        for (int pass = 0; pass < 2; pass++) begin
            tmr_en = 1'b0;
            step();
            write_mode(pass[0]);
            tmr_en = 1'b1;
            for (int c = 0; c < 400; c++) begin
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                phase_in = lfsr[2:0];
                if (c % 50 == 0) dt_width = 8'(lfsr[6:4]);
                step();
                if ((gate_top & gate_bot) != 3'b000) bad++;
            end
        end
        n_checks++;
        if (bad != 0) begin
            n_fails++;
            $display("FAIL R9: overlap cycles=%0d expected 0", bad);
        end
    endtask

    task automatic t_final_stop();
        tmr_en = 1'b0;
        step(); expect_gates("R6 final stop", 3'b000, 3'b000);
    endtask

    initial begin
        t_reset();
        t_startup();
        t_basic_gap();
        t_narrow_restart();
        t_stop_and_switch();
        t_narrow_shrink();
        t_mode_lock();
        t_zero_width();
        t_independent();
        t_overlap_sweep();
        t_final_stop();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
            $finish;
        end
    end

endmodule